// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block gathers the data bytes of one write burst aimed at a single 128-byte page of a serial memory array, and later hands the whole page back to the array in one pass. When the protocol engine announces a new write with a 17-bit start address, the buffer takes the page that holds that address. It then reads the current array contents of that page into its byte store, one byte per cycle, so that every location has a defined value before any commit. Incoming data bytes land at a pointer whose low 7 bits count up and wrap inside the page. The upper 10 bits never move, so a long burst overwrites its own earlier bytes in arrival order, and a burst that starts mid-page folds back to the start of the same page.

On a commit request the buffer streams all 128 bytes of the page, in ascending order and one per cycle, with full array addresses. Bytes that arrived carry their new values. Bytes that did not arrive carry the values captured during the pre-fill, which refreshes them. A per-byte received mask makes a commit with nothing received produce no array writes at all. The pointer output tells the protocol engine where the next access continues.

Top module: `page_write_buffer`

## Requirements
- R1: After a synchronous reset, `ptr_o` is 0, `busy_o` is 0 and `cm_we_o` is 0.
- R2: A load accepted while idle or ready sets `ptr_o` to `load_addr_i` on the next cycle. The buffer then reads the page with `rd_req_o`, using addresses `{load_addr_i[16:7], k}` for k = 0 up to 127 in ascending order. `rd_data_i` must hold the array byte in the cycle after each request.
- R3: Each accepted byte is stored at the offset `ptr_o[6:0]`. After it, `ptr_o[6:0]` steps by one modulo 128 and `ptr_o[16:7]` stays unchanged. Offset 127 therefore wraps to offset 0 of the same page, and after a single byte the pointer names the next location.
- R4: When more than 128 bytes arrive before a commit, later bytes replace earlier ones at the same offset. The last byte received for an offset is the one committed.
- R5: A commit with at least one received byte drives `cm_we_o` high for 128 consecutive cycles. `cm_addr_o` is `{page, k}` for k = 0 up to 127, and `cm_data_o` is the received byte for received offsets or the pre-filled array byte for all others.
- R6: A commit with no received byte produces no `cm_we_o` pulse, and the block returns to idle.
- R7: A byte accepted while the pre-fill is running is never overwritten by the pre-fill, whatever the cycle of its arrival relative to the read of that offset.
- R8: A commit requested during the pre-fill is held. It runs once the pre-fill has finished, and no commit write appears before all 128 pre-fill reads have been issued.
- R9: While idle (no page loaded), byte strobes and commit requests are ignored: `ptr_o` stays unchanged and no commit write appears.
- R10: In the ready state, a commit takes priority over a load, and a load takes priority over a byte strobe. A byte strobe in the same cycle as a commit is dropped and does not move `ptr_o`.
- R11: `busy_o` is high from the cycle after a load is accepted until the pre-fill ends, and from a commit request until the last commit write has been presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a new page with the given start address |
| load_addr_i | input | 17 | Start address of the write burst |
| wr_i | input | 1 | One data byte is present |
| wr_data_i | input | 8 | Data byte |
| commit_i | input | 1 | Request that the page be written to the array |
| rd_req_o | output | 1 | Pre-fill read request to the array |
| rd_addr_o | output | 17 | Pre-fill read address |
| rd_data_i | input | 8 | Array byte, valid the cycle after a read request |
| cm_we_o | output | 1 | Commit write strobe to the array |
| cm_addr_o | output | 17 | Commit write address |
| cm_data_o | output | 8 | Commit write data |
| ptr_o | output | 17 | Address pointer for the next access |
| busy_o | output | 1 | Pre-fill or commit in progress |

## Verification
The byte store has one write port, so an incoming data byte and a returning pre-fill byte can fall in the same cycle. That collision is provoked by sending a burst of back-to-back bytes immediately after a load, while the pre-fill is still reading the page. The outcome is judged at the commit port: every received offset must carry its received value and every other offset its array value. A second overlap, a commit request arriving during the pre-fill, is judged by checking that no commit write comes before the 128th pre-fill read.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_READY  = 2'd2,
    ST_COMMIT = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_ram.sv
// Byte store: one write port, one registered read port (block RAM style).
module pwb_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwb_fill.sv
// Pre-fill sequencer: reads the page from the array and offers each byte
// for the store. A byte write owns the store port; a returning byte that
// meets one is parked in a one-entry stash and issuing pauses meanwhile.
module pwb_fill #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              blocked_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              put_o,
  output logic [IDX_W-1:0]  put_idx_o,
  output logic [DATA_W-1:0] put_data_o,
  output logic              done_o
);
  logic              active;
  logic [IDX_W:0]    issued;
  logic              pend;
  logic [IDX_W-1:0]  pend_idx;
  logic              stash_v;
  logic [IDX_W-1:0]  stash_idx;
  logic [DATA_W-1:0] stash_data;

  always_comb begin
    rd_req_o   = active && !issued[IDX_W] && !stash_v && !(pend && blocked_i);
    rd_idx_o   = issued[IDX_W-1:0];
    put_o      = 1'b0;
    put_idx_o  = pend_idx;
    put_data_o = rd_data_i;
    if (stash_v) begin
      put_idx_o  = stash_idx;
      put_data_o = stash_data;
      put_o      = !blocked_i;
    end else if (pend) begin
      put_o = !blocked_i;
    end
    done_o = active && issued[IDX_W] && !pend && !stash_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      issued     <= '0;
      pend       <= 1'b0;
      pend_idx   <= '0;
      stash_v    <= 1'b0;
      stash_idx  <= '0;
      stash_data <= '0;
    end else if (start_i) begin
      active  <= 1'b1;
      issued  <= '0;
      pend    <= 1'b0;
      stash_v <= 1'b0;
    end else begin
      if (done_o) active <= 1'b0;
      if (rd_req_o) issued <= issued + 1'b1;
      pend     <= rd_req_o;
      pend_idx <= rd_idx_o;
      if (pend && blocked_i) begin
        stash_v    <= 1'b1;
        stash_idx  <= pend_idx;
        stash_data <= rd_data_i;
      end else if (stash_v && !blocked_i) begin
        stash_v <= 1'b0;
      end
    end
  end

  // R2: consecutive reads walk the page upward by one offset
  p_fill_ascend_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && $past(rd_req_o)) |-> (rd_idx_o == $past(rd_idx_o) + IDX_W'(1)));

  // R7: a parked byte and an outstanding read never coexist
  p_stash_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(stash_v && pend));

  // R7: a parked byte leaves the stash as soon as the port is free
  p_stash_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (stash_v && !blocked_i && !start_i) |=> !stash_v);
endmodule

// File: rtl/pwb_drain.sv
// Commit sequencer: sweeps all offsets of the page, registering the
// strobe and address alongside the store's registered read data.
module pwb_drain #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [IDX_W-1:0]  raddr_o,
  output logic              last_o,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o
);
  logic              active;
  logic [IDX_W-1:0]  cnt;
  logic [PAGE_W-1:0] page_q;

  assign raddr_o = cnt;
  assign last_o  = active && (cnt == {IDX_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      page_q    <= '0;
      cm_we_o   <= 1'b0;
      cm_addr_o <= '0;
    end else begin
      cm_we_o   <= active;
      cm_addr_o <= {page_q, cnt};
      if (start_i) begin
        active <= 1'b1;
        cnt    <= '0;
        page_q <= page_i;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (last_o) active <= 1'b0;
      end
    end
  end

  // R5: commit writes step through consecutive addresses
  p_cm_ascend_r5: assert property (@(posedge clk) disable iff (rst)
    (cm_we_o && $past(cm_we_o)) |-> (cm_addr_o == $past(cm_addr_o) + ADDR_W'(1)));

  // R5: every commit sweep begins at offset zero of the page
  p_cm_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cm_we_o) |-> (cm_addr_o[IDX_W-1:0] == '0));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              busy_o
);
  import pwb_pkg::*;

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;

  pwb_state_e            state;
  logic [PAGE_W-1:0]     page_q;
  logic [IDX_W-1:0]      ofs_q;
  logic [PAGE_BYTES-1:0] recv_q;
  logic                  commit_pend;

  logic in_load, in_ready, commit_go, load_take, wr_take, have_data;

  logic              fill_rd_req, fill_put, fill_done;
  logic [IDX_W-1:0]  fill_rd_idx, fill_put_idx;
  logic [DATA_W-1:0] fill_put_data;

  logic              drain_start, drain_last;
  logic [IDX_W-1:0]  drain_raddr;

  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  // Priority in ready: commit, then load, then byte strobe.
  always_comb begin
    in_load   = (state == ST_LOAD);
    in_ready  = (state == ST_READY);
    have_data = |recv_q;
    commit_go = in_ready && (commit_i || commit_pend);
    load_take = load_i && ((state == ST_IDLE) || (in_ready && !commit_go));
    wr_take   = wr_i && (in_load || (in_ready && !commit_go && !load_i));
    drain_start = commit_go && have_data;
  end

  // Store write port: a received byte wins; a pre-fill byte only lands
  // where nothing has been received.
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = ofs_q;
    ram_wdata = wr_data_i;
    if (wr_take) begin
      ram_we = 1'b1;
    end else if (fill_put && !recv_q[fill_put_idx]) begin
      ram_we    = 1'b1;
      ram_waddr = fill_put_idx;
      ram_wdata = fill_put_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      page_q      <= '0;
      ofs_q       <= '0;
      recv_q      <= '0;
      commit_pend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load_take) begin
            state  <= ST_LOAD;
            page_q <= load_addr_i[ADDR_W-1:IDX_W];
            ofs_q  <= load_addr_i[IDX_W-1:0];
            recv_q <= '0;
          end
        end
        ST_LOAD: begin
          if (commit_i) commit_pend <= 1'b1;
          if (fill_done) state <= ST_READY;
        end
        ST_READY: begin
          if (commit_go) begin
            commit_pend <= 1'b0;
            state       <= have_data ? ST_COMMIT : ST_IDLE;
          end else if (load_take) begin
            state  <= ST_LOAD;
            page_q <= load_addr_i[ADDR_W-1:IDX_W];
            ofs_q  <= load_addr_i[IDX_W-1:0];
            recv_q <= '0;
          end
        end
        default: begin
          if (drain_last) state <= ST_IDLE;
        end
      endcase
      if (wr_take) begin
        ofs_q         <= ofs_q + 1'b1;
        recv_q[ofs_q] <= 1'b1;
      end
    end
  end

  pwb_fill #(
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .IDX_W      (IDX_W)
  ) u_fill (
    .clk        (clk),
    .rst        (rst),
    .start_i    (load_take),
    .blocked_i  (wr_take),
    .rd_data_i  (rd_data_i),
    .rd_req_o   (fill_rd_req),
    .rd_idx_o   (fill_rd_idx),
    .put_o      (fill_put),
    .put_idx_o  (fill_put_idx),
    .put_data_o (fill_put_data),
    .done_o     (fill_done)
  );

  pwb_drain #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .IDX_W      (IDX_W),
    .PAGE_W     (PAGE_W)
  ) u_drain (
    .clk       (clk),
    .rst       (rst),
    .start_i   (drain_start),
    .page_i    (page_q),
    .raddr_o   (drain_raddr),
    .last_o    (drain_last),
    .cm_we_o   (cm_we_o),
    .cm_addr_o (cm_addr_o)
  );

  pwb_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (PAGE_BYTES)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (drain_raddr),
    .rdata (cm_data_o)
  );

  assign rd_req_o  = fill_rd_req;
  assign rd_addr_o = {page_q, fill_rd_idx};
  assign ptr_o     = {page_q, ofs_q};
  assign busy_o    = in_load || (state == ST_COMMIT) || commit_pend || cm_we_o;

  // R3: a taken byte advances only the in-page offset
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> ((ptr_o[ADDR_W-1:IDX_W] == $past(ptr_o[ADDR_W-1:IDX_W])) &&
                 (ptr_o[IDX_W-1:0] == $past(ptr_o[IDX_W-1:0]) + IDX_W'(1))));

  // R6: commit with nothing received goes idle without a write
  p_empty_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (commit_go && !have_data) |=> ((state == ST_IDLE) && !cm_we_o));

  // R8: no commit write while the page is still being read
  p_no_commit_in_load_r8: assert property (@(posedge clk) disable iff (rst)
    in_load |-> !cm_we_o);

  // R9: the pointer holds while idle unless a load arrives
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !load_i) |=> $stable(ptr_o));

  // R10: a byte strobe beside an accepted commit leaves the pointer alone
  p_commit_beats_write_r10: assert property (@(posedge clk) disable iff (rst)
    (commit_go && wr_i) |=> $stable(ptr_o));
endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [16:0] load_addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        commit_i = 1'b0;
  logic        rd_req_o;
  logic [16:0] rd_addr_o;
  logic [7:0]  rd_data_i = '0;
  logic        cm_we_o;
  logic [16:0] cm_addr_o;
  logic [7:0]  cm_data_o;
  logic [16:0] ptr_o;
  logic        busy_o;

  page_write_buffer uut (
    .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .commit_i(commit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .cm_we_o(cm_we_o), .cm_addr_o(cm_addr_o), .cm_data_o(cm_data_o),
    .ptr_o(ptr_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int rd_n = 0, rd_err = 0;
  int cm_n = 0, cm_err = 0, cm_early = 0;
  logic [9:0]  cur_page = '0;
  logic [16:0] eptr = '0;
  logic [7:0]  expv [128];
  logic [7:0]  cap  [128];

  function automatic logic [7:0] arr_val(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'h2B};
  endfunction

  // array model: registered read, one cycle latency
  always @(posedge clk) rd_data_i <= arr_val(rd_addr_o);

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req_o) begin
        if (rd_addr_o !== {cur_page, rd_n[6:0]}) rd_err++;
        rd_n++;
      end
      if (cm_we_o) begin
        if (rd_n < 128) cm_early++;
        if (cm_addr_o !== {cur_page, cm_n[6:0]}) cm_err++;
        cap[cm_addr_o[6:0]] = cm_data_o;
        cm_n++;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
  endtask

  // caller sits at a negedge
  task automatic do_load(logic [16:0] a);
    cur_page = a[16:7];
    eptr = a;
    rd_n = 0; rd_err = 0;
    for (int i = 0; i < 128; i++) expv[i] = arr_val({a[16:7], 7'(i)});
    load_i = 1'b1; load_addr_i = a;
    @(negedge clk);
    load_i = 1'b0;
    chk("R2 pointer after load", ptr_o, a);
    chk("R11 busy during prefill", busy_o, 1);
  endtask

  task automatic check_prefill();
    chk("R2 prefill read count", rd_n, 128);
    chk("R2 prefill read address order", rd_err, 0);
  endtask

  task automatic send_byte(logic [7:0] d);
    wr_i = 1'b1; wr_data_i = d;
    expv[eptr[6:0]] = d;
    eptr = {eptr[16:7], eptr[6:0] + 7'd1};
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic pulse_commit();
    cm_n = 0; cm_err = 0; cm_early = 0;
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic verify_commit(string req, int exp_n);
    int mism = 0;
    wait_idle();
    chk({req, " commit write count"}, cm_n, exp_n);
    if (exp_n == 128) begin
      chk({req, " commit address sequence"}, cm_err, 0);
      for (int i = 0; i < 128; i++) begin
        if (cap[i] !== expv[i]) begin
          if (mism == 0)
            $display("FAIL %s data at offset %0d: actual %0h expected %0h", req, i, cap[i], expv[i]);
          mism++;
        end
      end
      n_chk++;
      if (mism != 0) n_fail++;
    end
    chk({req, " busy low after commit"}, busy_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 pointer at reset", ptr_o, 0);
    chk("R1 busy at reset", busy_o, 0);
    chk("R1 no commit write at reset", cm_we_o, 0);
  endtask

  task automatic t_single_byte();
    do_load(17'h12345);
    wait_idle();
    check_prefill();
    send_byte(8'hA5);
    chk("R3 pointer after single byte", ptr_o, 17'h12346);
    pulse_commit();
    chk("R11 busy during commit", busy_o, 1);
    verify_commit("R5", 128);
  endtask

  task automatic t_page_wrap();
    do_load(17'h0FFFE);
    wait_idle();
    check_prefill();
    for (int i = 0; i < 4; i++) send_byte(8'h30 + 8'(i));
    chk("R3 pointer wraps inside page", ptr_o, 17'h0FF82);
    pulse_commit();
    verify_commit("R3", 128);
  endtask

  task automatic t_overflow();
    do_load(17'h00200);
    wait_idle();
    for (int i = 0; i < 130; i++) send_byte(8'(i));
    chk("R4 pointer after 130 bytes", ptr_o, 17'h00202);
    pulse_commit();
    verify_commit("R4", 128);
  endtask

  task automatic t_empty_commit();
    do_load(17'h05500);
    wait_idle();
    pulse_commit();
    verify_commit("R6", 0);
  endtask

  task automatic t_collide();
    do_load(17'h1FF80);
    for (int i = 0; i < 6; i++) send_byte(8'hC0 + 8'(i));
    repeat (20) @(negedge clk);
    send_byte(8'hEE);
    send_byte(8'hEF);
    wait_idle();
    check_prefill();
    chk("R7 pointer after writes during prefill", ptr_o, 17'h1FF88);
    pulse_commit();
    verify_commit("R7", 128);
  endtask

  task automatic t_deferred();
    do_load(17'h0A040);
    send_byte(8'h5C);
    send_byte(8'h5D);
    pulse_commit();
    chk("R8 busy while commit held", busy_o, 1);
    verify_commit("R8", 128);
    chk("R8 no commit write before prefill end", cm_early, 0);
  endtask

  task automatic t_idle_ignore();
    logic [16:0] p;
    p = ptr_o;
    wr_i = 1'b1; wr_data_i = 8'h77;
    repeat (3) @(negedge clk);
    wr_i = 1'b0;
    chk("R9 pointer holds in idle", ptr_o, p);
    pulse_commit();
    repeat (5) @(negedge clk);
    chk("R9 commit in idle writes nothing", cm_n, 0);
    chk("R9 busy stays low in idle", busy_o, 0);
  endtask

  task automatic t_commit_priority();
    do_load(17'h04000);
    wait_idle();
    send_byte(8'h11);
    cm_n = 0; cm_err = 0; cm_early = 0;
    commit_i = 1'b1; wr_i = 1'b1; wr_data_i = 8'h99;
    @(negedge clk);
    commit_i = 1'b0; wr_i = 1'b0;
    chk("R10 byte beside commit dropped", ptr_o, 17'h04001);
    verify_commit("R10", 128);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_page_wrap();
    t_overflow();
    t_empty_commit();
    t_collide();
    t_deferred();
    t_idle_ignore();
    t_commit_priority();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule